// File: doc/BRIEF.md
# Display FIFO Refill Threshold Calculator

This block works out the two watermarks that govern when a display engine asks memory to refill its pixel FIFO. It takes the memory clock, the parameters of the pixel clock synthesiser (reference frequency, reference divider, feedback divider, post divider), the colour depth in bits per pixel and a set of DRAM timing figures. From these it derives the pixel clock and the number of memory clocks one FIFO transfer lasts. It then picks a fixed-point precision that suits that figure and produces a packed configuration word and a packed on/off threshold word. The FIFO is taken to be 128 bits wide and 32 entries deep.

A job is handed over with a start/ready handshake. Each rounded division runs on a shared iterative divider that yields one quotient bit per clock. When a job ends, `done` pulses for one cycle. If the job fails, `err` is raised and the two result words keep their previous contents. A job fails on a zero divisor, on a precision too large for the fixed-point format, or on thresholds that leave no margin.

Top module: `dda_calc`

## Requirements
- R1: Every division rounds to nearest, computing (n + floor(d/2)) / d with integer truncation.
- R2: The pixel clock is round(ref_freq·fb_div / (ref_div·post_div)).
- R3: Bytes per pixel is floor((bpp + 7)/8). The coarse transfer time is round(xclk·128 / (pixclk·bytes·8)).
- R4: The precision is the bit length of the coarse value plus one, with a coarse value of 0 counted as 1 bit. A precision above 11 ends the job with `err`.
- R5: The fine transfer time is round((xclk·128) << (11 − precision) / (pixclk·bytes·8)). The off threshold is the fine value times 28.
- R6: The on threshold is (4·burst_len + 3·max(ras_cas − 2, 0) + 2·ras_pct + wr_rec + cas_lat + rd_wr + coarse) << (11 − precision).
- R7: On success, `cfg_word` = fine | precision<<16 | loop_lat<<20 and `onoff_word` = on<<16 | off. Both are formed as 32-bit ORs.
- R8: When on + loop_lat ≥ off, `err` is set and both result words keep their previous values.
- R9: A zero divisor in any division (ref_div·post_div = 0, or pixclk·bytes = 0) sets `err` and leaves both result words unchanged.
- R10: `ready` is high only while idle. A job is accepted on a clock edge with `start` and `ready` both high, and its inputs are captured at that edge. `done` is a one-cycle pulse. `err` and the result words change only in the cycle where `done` is high. `ready` is already high in the `done` cycle, so a new job may be accepted there.
- R11: After reset, `ready`=1, `done`=0, `err`=0, and both words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new job |
| ready | output | 1 | Idle, able to accept a job |
| xclk | input | 16 | Memory clock frequency |
| ref_freq | input | 16 | Synthesiser reference frequency |
| ref_div | input | 10 | Reference divider |
| fb_div | input | 11 | Feedback divider |
| post_div | input | 4 | Post divider |
| bpp | input | 6 | Bits per pixel |
| burst_len | input | 4 | DRAM burst length |
| ras_cas | input | 4 | Row-to-column delay |
| ras_pct | input | 4 | Row active figure |
| wr_rec | input | 4 | Write recovery |
| cas_lat | input | 4 | Column latency |
| rd_wr | input | 4 | Read-to-write turnaround |
| loop_lat | input | 4 | Arbiter loop latency |
| done | output | 1 | One-cycle end-of-job pulse |
| err | output | 1 | Last job failed |
| cfg_word | output | 32 | Packed fine value, precision, loop latency |
| onoff_word | output | 32 | Packed on and off thresholds |

## Verification
The completion of one job and the acceptance of the next can fall in the same cycle, because `ready` is already high while `done` pulses. The bench provokes this by holding `start` high with fresh operands in every `done` cycle of a back-to-back chain. A behavioural model, checked on every clock, then requires that the finished job's results appear exactly at its `done` and stay frozen while the new job runs. The chain mixes failing and passing jobs, so a failure that follows a success must leave the earlier words in place.

// File: rtl/dda_pkg.sv
package dda_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VCLK,
    ST_COARSE,
    ST_FINE,
    ST_FINAL
  } dda_state_e;

  // Bit length of a value; zero is reported as one bit.
  function automatic logic [6:0] bit_len(input logic [63:0] v);
    logic [6:0] n;
    n = 7'd1;
    for (int i = 0; i < 64; i++)
      if (v[i]) n = 7'(i + 1);
    return n;
  endfunction

endpackage

// File: rtl/dda_rdiv.sv
module dda_rdiv #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic         dz,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W);
  localparam int W2 = 2 * W;

  logic         busy;
  logic [CW-1:0] cnt;
  logic [W:0]   rem;
  logic [W-1:0] acc, dv, n_s;
  logic [W:0]   trial;
  logic         take;

  always_comb begin
    trial = {rem[W-1:0], acc[W-1]};
    take  = trial >= {1'b0, dv};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      rem  <= '0;
      acc  <= '0;
      dv   <= '0;
      n_s  <= '0;
      done <= 1'b0;
      dz   <= 1'b0;
      quo  <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        n_s <= num;
        dv  <= den;
        if (den == '0) begin
          done <= 1'b1;
          dz   <= 1'b1;
          quo  <= '0;
        end else begin
          dz   <= 1'b0;
          acc  <= num + (den >> 1);
          rem  <= '0;
          busy <= 1'b1;
          cnt  <= CW'(W - 1);
        end
      end else if (busy) begin
        rem <= take ? (trial - {1'b0, dv}) : trial;
        acc <= {acc[W-2:0], take};
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          quo  <= {acc[W-2:0], take};
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R1: quotient is the nearest-rounded ratio of the captured operands
  a_r1_round_nearest: assert property (@(posedge clk) disable iff (rst)
    (done && !dz) |->
      ((W2'(quo) * W2'(dv) <= W2'(n_s) + W2'(dv >> 1)) &&
       ((W2'(quo) + 1) * W2'(dv) > W2'(n_s) + W2'(dv >> 1))));

  // R9: zero flag matches a zero divisor
  a_r9_zero_flag: assert property (@(posedge clk) disable iff (rst)
    done |-> (dz == (dv == '0)));

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/dda_on_sum.sv
module dda_on_sum #(
  parameter int TW = 4,
  parameter int DW = 40
) (
  input  logic [TW-1:0] burst_len,
  input  logic [TW-1:0] ras_cas,
  input  logic [TW-1:0] ras_pct,
  input  logic [TW-1:0] wr_rec,
  input  logic [TW-1:0] cas_lat,
  input  logic [TW-1:0] rd_wr,
  input  logic [DW-1:0] coarse,
  output logic [DW-1:0] sum
);
  logic [DW-1:0] rc_adj;

  always_comb begin
    rc_adj = (ras_cas > TW'(2)) ? DW'(ras_cas - TW'(2)) : '0;
    sum = (DW'(burst_len) << 2) + (rc_adj * DW'(3)) + (DW'(ras_pct) << 1)
        + DW'(wr_rec) + DW'(cas_lat) + DW'(rd_wr) + coarse;
  end

endmodule

// File: rtl/dda_calc.sv
module dda_calc
  import dda_pkg::*;
#(
  parameter int XW         = 16,
  parameter int RFW        = 16,
  parameter int RDW        = 10,
  parameter int FBW        = 11,
  parameter int PDW        = 4,
  parameter int BPW        = 6,
  parameter int TW         = 4,
  parameter int LW         = 4,
  parameter int DW         = 40,
  parameter int FIFO_BITS  = 128,
  parameter int FIFO_DEPTH = 32,
  parameter int FRAC       = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output logic           ready,
  input  logic [XW-1:0]  xclk,
  input  logic [RFW-1:0] ref_freq,
  input  logic [RDW-1:0] ref_div,
  input  logic [FBW-1:0] fb_div,
  input  logic [PDW-1:0] post_div,
  input  logic [BPW-1:0] bpp,
  input  logic [TW-1:0]  burst_len,
  input  logic [TW-1:0]  ras_cas,
  input  logic [TW-1:0]  ras_pct,
  input  logic [TW-1:0]  wr_rec,
  input  logic [TW-1:0]  cas_lat,
  input  logic [TW-1:0]  rd_wr,
  input  logic [LW-1:0]  loop_lat,
  output logic           done,
  output logic           err,
  output logic [31:0]    cfg_word,
  output logic [31:0]    onoff_word
);
  localparam int OFF_MUL = FIFO_DEPTH - 4;
  localparam int PW      = 7;

  dda_state_e state;

  logic [XW-1:0]  x_q;
  logic [BPW-1:0] bytes_q;
  logic [TW-1:0]  bl_q, rc_q, rp_q, wr_q, cl_q, rw_q;
  logic [LW-1:0]  loop_q;
  logic [DW-1:0]  coarse_q, fine_q;
  logic [PW-1:0]  prec_q;

  logic           div_go, div_done, div_dz;
  logic [DW-1:0]  op_n, op_d, div_q;

  logic [DW-1:0]  xn, on_sum, on_v, off_v;
  logic [PW-1:0]  prec_n;
  logic [BPW:0]   bytes_n;

  dda_rdiv #(.W(DW)) u_div (
    .clk  (clk),
    .rst  (rst),
    .go   (div_go),
    .num  (op_n),
    .den  (op_d),
    .done (div_done),
    .dz   (div_dz),
    .quo  (div_q)
  );

  dda_on_sum #(.TW(TW), .DW(DW)) u_sum (
    .burst_len (bl_q),
    .ras_cas   (rc_q),
    .ras_pct   (rp_q),
    .wr_rec    (wr_q),
    .cas_lat   (cl_q),
    .rd_wr     (rw_q),
    .coarse    (coarse_q),
    .sum       (on_sum)
  );

  always_comb begin
    ready   = (state == ST_IDLE);
    xn      = DW'(x_q) * DW'(FIFO_BITS);
    prec_n  = bit_len(64'(div_q)) + PW'(1);
    bytes_n = ({1'b0, bpp} + (BPW+1)'(7)) >> 3;
    off_v   = fine_q * DW'(OFF_MUL);
    on_v    = on_sum << (PW'(FRAC) - prec_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      err        <= 1'b0;
      cfg_word   <= '0;
      onoff_word <= '0;
      div_go     <= 1'b0;
      op_n       <= '0;
      op_d       <= '0;
      x_q        <= '0;
      bytes_q    <= '0;
      bl_q       <= '0;
      rc_q       <= '0;
      rp_q       <= '0;
      wr_q       <= '0;
      cl_q       <= '0;
      rw_q       <= '0;
      loop_q     <= '0;
      coarse_q   <= '0;
      fine_q     <= '0;
      prec_q     <= '0;
    end else begin
      done   <= 1'b0;
      div_go <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          x_q     <= xclk;
          bytes_q <= BPW'(bytes_n);
          bl_q    <= burst_len;
          rc_q    <= ras_cas;
          rp_q    <= ras_pct;
          wr_q    <= wr_rec;
          cl_q    <= cas_lat;
          rw_q    <= rd_wr;
          loop_q  <= loop_lat;
          op_n    <= DW'(ref_freq) * DW'(fb_div);
          op_d    <= DW'(ref_div) * DW'(post_div);
          div_go  <= 1'b1;
          state   <= ST_VCLK;
        end
        ST_VCLK: if (div_done) begin
          if (div_dz) begin
            done  <= 1'b1;
            err   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            op_n   <= xn;
            op_d   <= div_q * DW'(bytes_q) * DW'(8);
            div_go <= 1'b1;
            state  <= ST_COARSE;
          end
        end
        ST_COARSE: if (div_done) begin
          if (div_dz || (prec_n > PW'(FRAC))) begin
            done  <= 1'b1;
            err   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            coarse_q <= div_q;
            prec_q   <= prec_n;
            op_n     <= xn << (PW'(FRAC) - prec_n);
            div_go   <= 1'b1;
            state    <= ST_FINE;
          end
        end
        ST_FINE: if (div_done) begin
          fine_q <= div_q;
          state  <= ST_FINAL;
        end
        ST_FINAL: begin
          done  <= 1'b1;
          state <= ST_IDLE;
          if (on_v + DW'(loop_q) >= off_v) begin
            err <= 1'b1;
          end else begin
            err        <= 1'b0;
            cfg_word   <= 32'(fine_q) | (32'(prec_q) << 16) | (32'(loop_q) << 20);
            onoff_word <= (32'(on_v) << 16) | 32'(off_v);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8 / R9: a failed job leaves both result words as they were
  a_r8_fail_holds: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> ($stable(cfg_word) && $stable(onoff_word)));

  // R10: result words move only in the completion cycle
  a_r10_words_only_at_done: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(cfg_word) && $stable(onoff_word) && $stable(err)));

  // R10: an accepted job leaves the idle state
  a_r10_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> !ready);

  // R4: a successful result carries a precision between 1 and the fraction limit
  a_r4_prec_range: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> ((cfg_word[19:16] >= 4'd1) && (32'(cfg_word[19:16]) <= 32'(FRAC))));

endmodule

// File: tb/dda_calc_test.sv
module dda_calc_test;
  typedef struct {
    int x, rf, rd, fb, pd, bpp, bl, rc, rp, wr, cl, rw, lp;
    string tag;
  } job_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic ready, done, err;
  logic [15:0] xclk, ref_freq;
  logic [9:0]  ref_div;
  logic [10:0] fb_div;
  logic [3:0]  post_div, burst_len, ras_cas, ras_pct, wr_rec, cas_lat, rd_wr, loop_lat;
  logic [5:0]  bpp;
  logic [31:0] cfg_word, onoff_word;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit mon_on = 0;
  job_t pend[$];
  logic [31:0] com_cfg = 0, com_onoff = 0;
  logic com_err = 0;

  always #10 clk = ~clk;

  dda_calc uut (
    .clk(clk), .rst(rst), .start(start), .ready(ready),
    .xclk(xclk), .ref_freq(ref_freq), .ref_div(ref_div), .fb_div(fb_div),
    .post_div(post_div), .bpp(bpp), .burst_len(burst_len), .ras_cas(ras_cas),
    .ras_pct(ras_pct), .wr_rec(wr_rec), .cas_lat(cas_lat), .rd_wr(rd_wr),
    .loop_lat(loop_lat), .done(done), .err(err),
    .cfg_word(cfg_word), .onoff_word(onoff_word)
  );

  function automatic longint blen(longint v);
    longint n = 1;
    for (int i = 0; i < 63; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  // Behavioural model of R1..R9
  function automatic void model(job_t j, output bit e, output logic [31:0] c, output logic [31:0] o);
    longint vd, vclk, bytes, d, n, coarse, prec, fine, off, on, rcm;
    e = 0; c = 0; o = 0;
    vd = longint'(j.rd) * j.pd;
    if (vd == 0) begin e = 1; return; end                      // R9
    vclk = (longint'(j.rf) * j.fb + vd / 2) / vd;                // R2, R1
    bytes = (j.bpp + 7) / 8;                                     // R3
    d = vclk * bytes * 8;
    if (d == 0) begin e = 1; return; end                       // R9
    n = longint'(j.x) * 128;
    coarse = (n + d / 2) / d;                                    // R3
    prec = blen(coarse) + 1;                                     // R4
    if (prec > 11) begin e = 1; return; end
    fine = ((n << (11 - prec)) + d / 2) / d;                     // R5
    off = fine * 28;
    rcm = (j.rc > 2) ? j.rc - 2 : 0;
    on = (4 * j.bl + 3 * rcm + 2 * j.rp + j.wr + j.cl + j.rw + coarse) << (11 - prec); // R6
    if (on + j.lp >= off) begin e = 1; return; end             // R8
    c = 32'(fine) | (32'(prec) << 16) | (32'(j.lp) << 20);       // R7
    o = (32'(on) << 16) | 32'(off);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares the ports against the model on every clock
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (done) begin
        job_t j;
        bit e; logic [31:0] c, o;
        chk(ready == 1'b1, "R10", "ready in done cycle", ready, 1);
        if (pend.size() == 0) chk(0, "R10", "done without job", 1, 0);
        else begin
          j = pend.pop_front();
          model(j, e, c, o);
          com_err = e;
          if (!e) begin com_cfg = c; com_onoff = o; end
          chk(err == e, j.tag, "err", err, e);
        end
      end
      chk(cfg_word == com_cfg, "R7", "cfg_word", cfg_word, com_cfg);
      chk(onoff_word == com_onoff, "R7", "onoff_word", onoff_word, com_onoff);
      chk(err == com_err, "R10", "err held", err, com_err);
    end
  end

  task automatic drive(job_t j);
    xclk = 16'(j.x); ref_freq = 16'(j.rf); ref_div = 10'(j.rd); fb_div = 11'(j.fb);
    post_div = 4'(j.pd); bpp = 6'(j.bpp); burst_len = 4'(j.bl); ras_cas = 4'(j.rc);
    ras_pct = 4'(j.rp); wr_rec = 4'(j.wr); cas_lat = 4'(j.cl); rd_wr = 4'(j.rw);
    loop_lat = 4'(j.lp);
  endtask

  task automatic launch(job_t j);
    drive(j);
    start = 1'b1;
    pend.push_back(j);
    @(negedge clk);
    start = 1'b0;
    drive('{x:0, rf:0, rd:0, fb:0, pd:0, bpp:0, bl:0, rc:0, rp:0, wr:0, cl:0, rw:0, lp:0, tag:""});
    chk(ready == 1'b0, "R10", "busy after accept", ready, 0);
  endtask

  task automatic issue(job_t j);
    @(negedge clk);
    while (!ready) @(negedge clk);
    launch(j);
  endtask

  // Start a new job in the very cycle the previous one completes
  task automatic chain(job_t j);
    @(negedge clk);
    while (!done) @(negedge clk);
    launch(j);
  endtask

  task automatic drain();
    while (pend.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic job_t mk(int x, int rf, int rd, int fb, int pd, int b, int bl, int rc,
                              int rp, int wr, int cl, int rw, int lp, string tag);
    job_t j;
    j.x = x; j.rf = rf; j.rd = rd; j.fb = fb; j.pd = pd; j.bpp = b; j.bl = bl; j.rc = rc;
    j.rp = rp; j.wr = wr; j.cl = cl; j.rw = rw; j.lp = lp; j.tag = tag;
    return j;
  endfunction

  function automatic job_t rnd();
    int depths[4] = '{8, 15, 16, 32};
    return mk($urandom_range(1, 65535), $urandom_range(1000, 4000), $urandom_range(1, 100),
              $urandom_range(20, 400), $urandom_range(1, 12), depths[$urandom_range(0, 3)],
              $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
              $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
              $urandom_range(0, 15), "R5");
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    drive(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, ""));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(ready == 1'b1, "R11", "ready", ready, 1);
    chk(done == 1'b0, "R11", "done", done, 0);
    chk(err == 1'b0, "R11", "err", err, 0);
    chk(cfg_word == 0 && onoff_word == 0, "R11", "words", cfg_word, 0);
    rst = 1'b0;
    mon_on = 1;
    // R2 R3 R5 R6 R7: 32-bit colour, normal figures, precision 5
    issue(mk(10000, 2950, 60, 130, 2, 32, 4, 3, 1, 1, 3, 1, 15, "R7"));
    drain();
    // R3: 15 bpp rounds up to 2 bytes; ras_cas below 2 clamps (R6)
    issue(mk(10000, 2950, 60, 130, 2, 15, 2, 1, 1, 1, 2, 1, 3, "R3"));
    drain();
    // R8: coarse value 0 (precision 2) gives on above off; words unchanged
    issue(mk(10, 2950, 60, 130, 2, 32, 4, 3, 1, 1, 3, 1, 2, "R8"));
    drain();
    // R4: precision above 11 is rejected
    issue(mk(60000, 2950, 60, 10, 8, 8, 1, 1, 1, 1, 1, 1, 1, "R4"));
    drain();
    // R9: zero reference divider, then zero bytes per pixel
    issue(mk(10000, 2950, 0, 130, 2, 32, 4, 3, 1, 1, 3, 1, 1, "R9"));
    drain();
    issue(mk(10000, 2950, 60, 130, 2, 0, 4, 3, 1, 1, 3, 1, 1, "R9"));
    drain();
    // R1: 8 bpp case with a tie-prone ratio
    issue(mk(12800, 3000, 30, 100, 4, 8, 1, 2, 0, 0, 1, 0, 0, "R1"));
    drain();
    // R10: back-to-back jobs accepted in the done cycle, mixing pass and fail
    issue(mk(10000, 2950, 60, 130, 2, 16, 4, 4, 2, 1, 3, 1, 5, "R10"));
    chain(mk(10, 2950, 60, 130, 2, 32, 4, 3, 1, 1, 3, 1, 2, "R10"));
    chain(mk(20000, 2950, 60, 200, 2, 32, 2, 5, 1, 2, 2, 1, 7, "R10"));
    chain(mk(10000, 2950, 0, 130, 2, 32, 4, 3, 1, 1, 3, 1, 1, "R10"));
    chain(mk(9000, 2950, 60, 150, 3, 8, 3, 3, 3, 3, 3, 3, 3, "R10"));
    drain();
    // R5: assorted operands
    for (int k = 0; k < 60; k++) begin
      issue(rnd());
      drain();
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule